// File: doc/BRIEF.md
# SPI Real-Time-Clock Register Slave

This block is the device side of a serially attached real-time clock. A host talks to it over a four-wire SPI link in mode 0. Each transfer is a frame of 8-bit bytes, sent most significant bit first. The first byte of a frame is an opcode and the second is a register address. Every byte after that is data. In a read, the data comes back from the block; in a write, it goes into the block. The address steps up by one after each data byte.

The register file holds the time of day in BCD. Some control flags sit inside the same bytes as the time fields: a start bit shares the seconds byte, a 12-hour select bit shares the hours byte, and a leap-year bit shares the month byte. A slow `tick` strobe stands in for the crystal oscillator.

An oscillator-running flag can be read back but not written. It follows the start bit only after a set number of ticks. Software must therefore poll this flag after starting or stopping the clock. While the flag is set, each tick advances the BCD seconds.

The SPI pins are sampled by the block's own clock through two-stage synchronisers, so SCK must stay well below a quarter of the clock rate. The link has no back-pressure. Every byte the host clocks in is accepted, and every byte it clocks out must be ready before its first rising SCK edge. The block prepares that byte on the rising edge that ends the previous byte.

Top module: `rtc_spi_regslave`

## Requirements
- R1: Frames use SPI mode 0. MOSI is sampled on rising SCK and MISO changes after falling SCK. Bytes are sent MSB first. Raising `spi_cs_n` discards any partial byte, and the next frame starts cleanly with an opcode.
- R2: Opcode 0x13 is a read. The next byte selects a start address. Each following byte returns the register at the current address, and the address then advances by one.
- R3: Opcode 0x12 is a write. The next byte selects a start address. Each following byte is stored at the current address, and the address then advances by one.
- R4: Addresses are 5 bits wide; the upper three address-byte bits are ignored. During a burst the address wraps from 0x1F to 0x00.
- R5: Any other opcode makes the rest of the frame inert until CS rises. No register changes, even if a valid opcode appears later in the same frame, and MISO stays 0.
- R6: MISO is 0 whenever CS is high. It is also 0 throughout the opcode and address bytes of every frame.
- R7: Register 0x01 holds the start bit in bit 7 and BCD seconds in bits 6:0. Hours (0x03, bit 6 = 12-hour select), month (0x06, bit 5 = leap year, bits 4:0 = BCD month), year (0x07), control (0x08, bit 3 = external oscillator select) and the remaining addresses store whatever is written.
- R8: Register 0x04 reads its oscillator-running flag in bit 5. Writes to that bit are ignored, while the other bits of 0x04 store what is written.
- R9: When the start bit differs from the running flag, the flag takes the start bit's value on the LAG_TICKS-th tick (default 3). This applies to both starting and stopping.
- R10: On a tick while the running flag is set, the seconds count advances in BCD from 00 to 59 and then wraps to 00. The start bit is kept. With the flag clear, ticks leave the seconds unchanged. A seconds write in the same cycle as a tick takes priority.
- R11: After reset, every register and the running flag read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also samples the SPI pins |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle oscillator strobe |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |

## Verification
The burst logic is tested with read and write bursts of several lengths from different start addresses, including one that crosses 0x1F. These tests separate a correct auto-increment from a fixed or non-wrapping address.

A frame with an unknown opcode carries a valid write opcode and data later in the same frame. This shows that the skip state lasts until CS rises and does not re-decode the opcode.

The oscillator sequence polls the running flag one tick before and one tick after the lag expires, in both the starting and the stopping direction. It also tracks the seconds across a low-digit carry and across the 59-to-00 wrap. This tells apart a flag that follows the start bit directly from one that trails it, and shows whether counting keys on the start bit or on the running flag.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;
  localparam int          BYTE_W  = 8;
  localparam logic [7:0]  OP_READ  = 8'h13;
  localparam logic [7:0]  OP_WRITE = 8'h12;
  localparam int          SEC_ADDR = 1;
  localparam int          WKD_ADDR = 4;
  localparam int          RUN_BIT  = 5;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_SKIP} phase_t;

  function automatic logic [6:0] bcd_sec_next(input logic [6:0] s);
    logic [6:0] n;
    if (s[3:0] == 4'd9) begin
      n[3:0] = 4'd0;
      n[6:4] = (s[6:4] == 3'd5) ? 3'd0 : s[6:4] + 3'd1;
    end else begin
      n[3:0] = s[3:0] + 4'd1;
      n[6:4] = s[6:4];
    end
    return n;
  endfunction
endpackage

// File: rtl/rtcs_spi_shift.sv
module rtcs_spi_shift
  import rtcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              spi_miso,
  output logic              cs_act,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CW = $clog2(BYTE_W);

  logic [SYNC_STAGES:0]   sck_p;
  logic [SYNC_STAGES-1:0] cs_p, mosi_p;
  logic                   sck_rise, sck_fall, mosi_s;
  logic [CW-1:0]          bit_cnt;
  logic [BYTE_W-2:0]      shin;
  logic [BYTE_W-1:0]      shout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[SYNC_STAGES-1:0], spi_sck};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], spi_cs_n};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], spi_mosi};
    end
  end

  assign sck_rise  = sck_p[SYNC_STAGES-1] & ~sck_p[SYNC_STAGES];
  assign sck_fall  = ~sck_p[SYNC_STAGES-1] & sck_p[SYNC_STAGES];
  assign mosi_s    = mosi_p[SYNC_STAGES-1];
  assign cs_act    = ~cs_p[SYNC_STAGES-1];
  assign byte_done = cs_act & sck_rise & (bit_cnt == CW'(BYTE_W-1));
  assign rx_byte   = {shin, mosi_s};
  assign spi_miso  = ~spi_cs_n & cs_act & shout[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n || !cs_act) begin
      bit_cnt <= '0;
      shin    <= '0;
      shout   <= '0;
    end else begin
      if (sck_rise) begin
        shin    <= {shin[BYTE_W-3:0], mosi_s};
        bit_cnt <= bit_cnt + CW'(1);
      end
      if (tx_load)
        shout <= tx_byte;
      else if (sck_fall && bit_cnt != '0)
        shout <= {shout[BYTE_W-2:0], 1'b0};
    end
  end

  a_r1_byte_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);
endmodule

// File: rtl/rtcs_ctrl.sv
module rtcs_ctrl
  import rtcs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  phase_t            phase;
  logic              is_rd;
  logic [ADDR_W-1:0] addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_CMD;
      is_rd <= 1'b0;
      addr  <= '0;
    end else if (!cs_act) begin
      phase <= PH_CMD;
    end else if (byte_done) begin
      unique case (phase)
        PH_CMD: begin
          if (rx_byte == OP_READ) begin
            is_rd <= 1'b1;
            phase <= PH_ADDR;
          end else if (rx_byte == OP_WRITE) begin
            is_rd <= 1'b0;
            phase <= PH_ADDR;
          end else begin
            phase <= PH_SKIP;
          end
        end
        PH_ADDR: begin
          addr  <= rx_byte[ADDR_W-1:0] + ADDR_W'(is_rd);
          phase <= PH_DATA;
        end
        PH_DATA: addr <= addr + ADDR_W'(1);
        default: phase <= PH_SKIP;
      endcase
    end
  end

  always_comb begin
    rd_addr = (phase == PH_ADDR) ? rx_byte[ADDR_W-1:0] : addr;
    tx_load = byte_done;
    tx_byte = (is_rd && (phase == PH_ADDR || phase == PH_DATA)) ? rd_data : '0;
    wr_en   = byte_done && phase == PH_DATA && !is_rd;
    wr_addr = addr;
    wr_data = rx_byte;
  end

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && cs_act && phase == PH_DATA) |=> addr == $past(addr) + ADDR_W'(1));
endmodule

// File: rtl/rtcs_regs.sv
module rtcs_regs
  import rtcs_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int LAG_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LW    = $clog2(LAG_TICKS + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic              running;
  logic [LW-1:0]     lag_cnt;
  logic              start_bit, sec_wr;

  assign start_bit = mem[SEC_ADDR][BYTE_W-1];
  assign sec_wr    = wr_en && wr_addr == ADDR_W'(SEC_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (tick && running && !sec_wr)
        mem[SEC_ADDR] <= {start_bit, bcd_sec_next(mem[SEC_ADDR][6:0])};
      if (wr_en)
        mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      lag_cnt <= '0;
    end else if (running == start_bit) begin
      lag_cnt <= '0;
    end else if (tick) begin
      if (lag_cnt == LW'(LAG_TICKS - 1)) begin
        running <= start_bit;
        lag_cnt <= '0;
      end else begin
        lag_cnt <= lag_cnt + LW'(1);
      end
    end
  end

  always_comb begin
    rd_data = mem[rd_addr];
    if (rd_addr == ADDR_W'(WKD_ADDR)) rd_data[RUN_BIT] = running;
  end

  a_r9_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (running != $past(running)) |-> $past(tick));
  a_r10_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && running && !wr_en && mem[SEC_ADDR][6:0] == 7'h59)
      |=> mem[SEC_ADDR][6:0] == 7'h00);
  a_r10_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_en) |=> $stable(mem[SEC_ADDR]));
endmodule

// File: rtl/rtc_spi_regslave.sv
module rtc_spi_regslave
  import rtcs_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int LAG_TICKS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  logic              cs_act, byte_done, tx_load, wr_en;
  logic [BYTE_W-1:0] rx_byte, tx_byte, rd_data, wr_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr;

  rtcs_spi_shift #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .tx_load(tx_load), .tx_byte(tx_byte),
    .spi_miso(spi_miso), .cs_act(cs_act), .byte_done(byte_done),
    .rx_byte(rx_byte));

  rtcs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .byte_done(byte_done),
    .rx_byte(rx_byte), .rd_data(rd_data), .tx_load(tx_load),
    .tx_byte(tx_byte), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data));

  rtcs_regs #(.ADDR_W(ADDR_W), .LAG_TICKS(LAG_TICKS)) u_regs (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data));
endmodule

// File: tb/test_rtc_spi_regslave.sv
module test_rtc_spi_regslave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  int   n_chk = 0, n_fail = 0;
  logic [7:0] rbuf [16];
  logic [7:0] wbuf [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_spi_regslave i_rtc_spi_regslave (
    .clk(clk), .rst_n(rst_n), .tick(tick), .spi_sck(sck),
    .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso));

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    wait_clk(2); cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic cs_hi();
    wait_clk(HALF); cs_n = 1'b1; wait_clk(HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic read_regs(input logic [7:0] a, input int n);
    logic [7:0] r;
    cs_lo();
    xfer(8'h13, r); check("R6 opcode byte", r, 8'h00);
    xfer(a, r);     check("R6 address byte", r, 8'h00);
    for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
    cs_hi();
  endtask

  task automatic write_regs(input logic [7:0] a, input int n);
    logic [7:0] r;
    cs_lo();
    xfer(8'h12, r);
    xfer(a, r);
    for (int i = 0; i < n; i++) xfer(wbuf[i], r);
    cs_hi();
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      wait_clk(2);
    end
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    wbuf[0] = d; write_regs(a, 1);
  endtask

  task automatic t_reset();
    check("R6 miso idle", {7'd0, miso}, 8'h00);
    read_regs(8'h00, 9);
    for (int i = 0; i < 9; i++) check("R11 reset value", rbuf[i], 8'h00);
  endtask

  task automatic t_burst();
    wbuf[0] = 8'h45; wbuf[1] = 8'h52; wbuf[2] = 8'h27; wbuf[3] = 8'h31;
    wbuf[4] = 8'h32; wbuf[5] = 8'h99; wbuf[6] = 8'h08;
    write_regs(8'h02, 7);
    read_regs(8'h02, 7);
    check("R3 minutes", rbuf[0], 8'h45);
    check("R7 hours 12h flag", rbuf[1], 8'h52);
    check("R8 run bit read-only", rbuf[2], 8'h07);
    check("R2 date", rbuf[3], 8'h31);
    check("R7 month leap flag", rbuf[4], 8'h32);
    check("R7 year", rbuf[5], 8'h99);
    check("R7 control ext osc", rbuf[6], 8'h08);
    check("R6 miso after cs rise", {7'd0, miso}, 8'h00);
  endtask

  task automatic t_wrap();
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    write_regs(8'hFE, 3);
    read_regs(8'h1F, 2);
    check("R4 addr 0x1F", rbuf[0], 8'hA2);
    check("R4 wrapped to 0x00", rbuf[1], 8'hA3);
  endtask

  task automatic t_unknown();
    logic [7:0] r;
    cs_lo();
    xfer(8'h55, r); check("R5 miso", r, 8'h00);
    xfer(8'h12, r); check("R5 miso", r, 8'h00);
    xfer(8'h02, r); check("R5 miso", r, 8'h00);
    xfer(8'hEE, r); check("R5 miso", r, 8'h00);
    cs_hi();
    read_regs(8'h02, 1);
    check("R5 register untouched", rbuf[0], 8'h45);
  endtask

  task automatic t_partial();
    logic [7:0] p;
    p = 8'h12;
    cs_lo();
    for (int i = 7; i >= 4; i--) begin
      mosi = p[i]; wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
    end
    cs_hi();
    wr1(8'h0A, 8'h5C);
    read_regs(8'h0A, 1);
    check("R1 frame realigned", rbuf[0], 8'h5C);
  endtask

  task automatic t_osc();
    wr1(8'h01, 8'h80);
    pulse_tick(2);
    read_regs(8'h04, 1); check("R9 lag start not yet", rbuf[0] & 8'h20, 8'h00);
    read_regs(8'h01, 1); check("R10 stopped no count", rbuf[0], 8'h80);
    pulse_tick(1);
    read_regs(8'h04, 1); check("R9 running after lag", rbuf[0] & 8'h20, 8'h20);
    read_regs(8'h01, 1); check("R10 start tick no count", rbuf[0], 8'h80);
    pulse_tick(2);
    read_regs(8'h01, 1); check("R10 count", rbuf[0], 8'h82);
    wr1(8'h01, 8'h89);
    pulse_tick(1);
    read_regs(8'h01, 1); check("R10 digit carry", rbuf[0], 8'h90);
    wr1(8'h01, 8'hD8);
    pulse_tick(1);
    read_regs(8'h01, 1); check("R10 count 59", rbuf[0], 8'hD9);
    pulse_tick(1);
    read_regs(8'h01, 1); check("R10 wrap 00", rbuf[0], 8'h80);
    wr1(8'h01, 8'h00);
    pulse_tick(2);
    read_regs(8'h04, 1); check("R9 lag stop still set", rbuf[0] & 8'h20, 8'h20);
    read_regs(8'h01, 1); check("R10 counts while flag set", rbuf[0], 8'h02);
    pulse_tick(1);
    read_regs(8'h04, 1); check("R9 stopped after lag", rbuf[0] & 8'h20, 8'h00);
    pulse_tick(1);
    read_regs(8'h01, 1); check("R10 hold when stopped", rbuf[0], 8'h03);
  endtask

  initial begin
    wait_clk(WD_CYCLES);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_burst();
    t_wrap();
    t_unknown();
    t_partial();
    t_osc();
    report();
    $finish;
  end
endmodule